// File: doc/BRIEF.md
# Instruction Format Class Decoder

This block sorts a 32-bit instruction word into exactly one of fifteen encoding classes and reports the register-number fields that the chosen class carries. Several classes share bit patterns with ordinary data processing, so the classifier applies a fixed priority and a few exclusion masks. It does not evaluate conditions, read registers or execute operands.

A front-end drops a word on `insn_i` with `valid_i` high. After one clock (with the default `REG_OUT = 1`), `valid_o` rises together with the one-hot `class_o`, the steered register fields, the condition nibble and the illegal-combination flag. While `valid_i` is low the output stage keeps its last contents. With `REG_OUT = 0` the stage is a wire and results follow the input in the same cycle.

Top module: `insn_class_decoder`

## Requirements
- R1: `class_o` has exactly one bit set in every cycle, including during reset.
- R2: A word with bits 27:4 equal to 0x12FFF1 is branch-and-exchange (`class_o` bit 4), ahead of every other class; `rm_o` is bits 3:0 and the other register fields are 0.
- R3: With bits 27:24 zero and bits 7:4 equal to 1001 the word is a multiply: bit 5 when bits 23:22 are 00, otherwise long multiply at bit 6. For both, `rd_o` = bits 19:16, `rn_o` = bits 15:12, `rs_o` = bits 11:8, `rm_o` = bits 3:0.
- R4: With bits 27:23 = 00010, bits 21:20 = 00 and bits 11:4 = 0x09 the word is a swap (bit 7), with `rn_o` = 19:16, `rd_o` = 15:12, `rm_o` = 3:0, `rs_o` = 0.
- R5: In groups 0 and 1 (bits 27:24), with bits 7 and 4 set, bits 7:4 above 1001 and not (bit 24 clear and bit 21 set), the word is a halfword transfer: bit 9 when bit 22 is set (immediate, `rm_o` = 0), else bit 8 (register, `rm_o` = 3:0); `rn_o` = 19:16, `rd_o` = 15:12, `rs_o` = 0.
- R6: In groups 4 to 7, bits 25 and 4 both set give the undefined class (bit 10, all fields 0); otherwise single data transfer (bit 1) with `rn_o` = 19:16, `rd_o` = 15:12, `rs_o` = 0 and `rm_o` = bits 3:0 only when bit 25 is set.
- R7: Groups 8–9 give block transfer (bit 2, `rn_o` = 19:16); 10–11 branch (bit 3); 12–13 coprocessor memory transfer (bit 13, `rn_o` = 19:16); 14 with bit 4 set coprocessor register transfer (bit 14, `rd_o` = 15:12), with bit 4 clear coprocessor operation (bit 12); 15 software interrupt (bit 11).
- R8: `illegal_o` is 1 exactly for a single data transfer with bit 24 clear and bit 21 set.
- R9: Any other word in groups 0–3 is data processing (bit 0) with `rn_o` = 19:16, `rd_o` = 15:12, `rs_o` = 11:8, `rm_o` = 3:0.
- R10: Register fields not listed for a class are 0; `cond_o` is bits 31:28 for every class.
- R11: With `REG_OUT = 1`, `valid_o` equals `valid_i` of the previous cycle; a word is captured only when `valid_i` is 1, otherwise all result outputs hold.
- R12: During reset `valid_o` is 0, `class_o` is data processing (bit 0), and all fields, `cond_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid |
| insn_i | input | 32 | Instruction word |
| valid_o | output | 1 | Result is valid |
| class_o | output | 15 | One-hot encoding class |
| cond_o | output | 4 | Condition nibble |
| rn_o | output | 4 | Base or first-operand register |
| rd_o | output | 4 | Destination register |
| rs_o | output | 4 | Shift or multiplier register |
| rm_o | output | 4 | Second-operand register |
| illegal_o | output | 1 | Post-indexed writeback on a single transfer |

## Verification
The bench targets the overlapping encodings. It uses words one bit away from branch-and-exchange, multiply words in each bits 23:22 setting, swap against halfword nibbles, and the halfword shape with post-indexed writeback, which must fall back to data processing. A decoder with a wrong priority or a missing exclusion mask would report swap or multiply as data processing, or report a halfword where none is allowed. Undefined against single transfer, the register-versus-immediate steering of `rm_o`, and the illegal flag on either side of its bit 24 / bit 21 condition catch a wrong bit index. Idle cycles between words catch a stage that loads without `valid_i`.

// File: rtl/insn_cls_pkg.sv
`timescale 1ns/1ps
package insn_cls_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_W     = 4;
  localparam int NUM_CLS   = 15;

  localparam int CLS_DP     = 0;
  localparam int CLS_SDT    = 1;
  localparam int CLS_BLOCK  = 2;
  localparam int CLS_BRANCH = 3;
  localparam int CLS_BX     = 4;
  localparam int CLS_MUL    = 5;
  localparam int CLS_MULL   = 6;
  localparam int CLS_SWAP   = 7;
  localparam int CLS_HW_REG = 8;
  localparam int CLS_HW_IMM = 9;
  localparam int CLS_UNDEF  = 10;
  localparam int CLS_SWI    = 11;
  localparam int CLS_CP_OP  = 12;
  localparam int CLS_CP_MEM = 13;
  localparam int CLS_CP_REG = 14;

  typedef logic [NUM_CLS-1:0] cls_vec_t;
  typedef logic [REG_W-1:0]   reg_idx_t;

  typedef struct packed {
    cls_vec_t cls;
    reg_idx_t cond;
    reg_idx_t rn;
    reg_idx_t rd;
    reg_idx_t rs;
    reg_idx_t rm;
    logic     illegal;
  } dec_res_t;

  localparam cls_vec_t CLS_RST = cls_vec_t'(1) << CLS_DP;
endpackage

// File: rtl/insn_class_decode.sv
`timescale 1ns/1ps
module insn_class_decode
  import insn_cls_pkg::*;
(
  input  logic [27:4] w_i,
  output cls_vec_t    cls_o,
  output logic        illegal_o
);
  logic [3:0] grp;
  logic [3:0] nib;
  logic is_bx, is_mul, is_swap, is_hw;

  assign grp = w_i[27:24];
  assign nib = w_i[7:4];

  assign is_bx   = (w_i[27:4] == 24'h12FFF1);
  assign is_mul  = (grp == 4'd0) && (nib == 4'b1001);
  assign is_swap = (w_i[27:23] == 5'b00010) && (w_i[21:20] == 2'b00) && (w_i[11:4] == 8'h09);
  // post-indexed writeback pattern is excluded from the halfword class
  assign is_hw   = (grp <= 4'd1) && w_i[7] && w_i[4] && (nib > 4'b1001) && !(!w_i[24] && w_i[21]);

  always_comb begin
    cls_o = '0;
    if (is_bx)                  cls_o[CLS_BX] = 1'b1;
    else if (grp < 4'd4) begin
      if (is_mul) begin
        if (w_i[23:22] == 2'b00) cls_o[CLS_MUL]  = 1'b1;
        else                     cls_o[CLS_MULL] = 1'b1;
      end
      else if (is_swap)         cls_o[CLS_SWAP] = 1'b1;
      else if (is_hw) begin
        if (w_i[22])            cls_o[CLS_HW_IMM] = 1'b1;
        else                    cls_o[CLS_HW_REG] = 1'b1;
      end
      else                      cls_o[CLS_DP] = 1'b1;
    end
    else if (grp < 4'd8) begin
      if (w_i[25] && w_i[4])    cls_o[CLS_UNDEF] = 1'b1;
      else                      cls_o[CLS_SDT]   = 1'b1;
    end
    else if (grp < 4'd10)       cls_o[CLS_BLOCK]  = 1'b1;
    else if (grp < 4'd12)       cls_o[CLS_BRANCH] = 1'b1;
    else if (grp < 4'd14)       cls_o[CLS_CP_MEM] = 1'b1;
    else if (grp == 4'd14) begin
      if (w_i[4])               cls_o[CLS_CP_REG] = 1'b1;
      else                      cls_o[CLS_CP_OP]  = 1'b1;
    end
    else                        cls_o[CLS_SWI] = 1'b1;
  end

  assign illegal_o = cls_o[CLS_SDT] && !w_i[24] && w_i[21];
endmodule

// File: rtl/insn_field_steer.sv
`timescale 1ns/1ps
module insn_field_steer
  import insn_cls_pkg::*;
(
  input  cls_vec_t cls_i,
  input  reg_idx_t f19_i,
  input  reg_idx_t f15_i,
  input  reg_idx_t f11_i,
  input  reg_idx_t f3_i,
  input  logic     reg_off_i,
  output reg_idx_t rn_o,
  output reg_idx_t rd_o,
  output reg_idx_t rs_o,
  output reg_idx_t rm_o
);
  always_comb begin
    rn_o = '0;
    rd_o = '0;
    rs_o = '0;
    rm_o = '0;
    unique case (1'b1)
      cls_i[CLS_DP]: begin
        rn_o = f19_i; rd_o = f15_i; rs_o = f11_i; rm_o = f3_i;
      end
      cls_i[CLS_MUL], cls_i[CLS_MULL]: begin
        rd_o = f19_i; rn_o = f15_i; rs_o = f11_i; rm_o = f3_i;
      end
      cls_i[CLS_SWAP], cls_i[CLS_HW_REG]: begin
        rn_o = f19_i; rd_o = f15_i; rm_o = f3_i;
      end
      cls_i[CLS_HW_IMM]: begin
        rn_o = f19_i; rd_o = f15_i;
      end
      cls_i[CLS_SDT]: begin
        rn_o = f19_i; rd_o = f15_i;
        if (reg_off_i) rm_o = f3_i;
      end
      cls_i[CLS_BX]:                        rm_o = f3_i;
      cls_i[CLS_BLOCK], cls_i[CLS_CP_MEM]:  rn_o = f19_i;
      cls_i[CLS_CP_REG]:                    rd_o = f15_i;
      cls_i[CLS_BRANCH], cls_i[CLS_UNDEF],
      cls_i[CLS_SWI], cls_i[CLS_CP_OP]: ;
      default: ;
    endcase
  end
endmodule

// File: rtl/insn_out_stage.sv
`timescale 1ns/1ps
module insn_out_stage
  import insn_cls_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  dec_res_t res_i,
  output logic     valid_o,
  output dec_res_t res_o
);
  localparam dec_res_t RES_RST = '{cls: CLS_RST, default: '0};

  if (REG_OUT) begin : g_reg
    dec_res_t res_q;
    logic     valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        res_q   <= RES_RST;
      end else begin
        valid_q <= valid_i;
        if (valid_i) res_q <= res_i;
      end
    end
    assign valid_o = valid_q;
    assign res_o   = res_q;
  end else begin : g_wire
    assign valid_o = valid_i;
    assign res_o   = res_i;
  end
endmodule

// File: rtl/insn_class_decoder.sv
`timescale 1ns/1ps
module insn_class_decoder
  import insn_cls_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [INSN_W-1:0]   insn_i,
  output logic                valid_o,
  output logic [NUM_CLS-1:0]  class_o,
  output logic [REG_W-1:0]    cond_o,
  output logic [REG_W-1:0]    rn_o,
  output logic [REG_W-1:0]    rd_o,
  output logic [REG_W-1:0]    rs_o,
  output logic [REG_W-1:0]    rm_o,
  output logic                illegal_o
);
  dec_res_t res_d, res_q;

  insn_class_decode u_decode (
    .w_i       (insn_i[27:4]),
    .cls_o     (res_d.cls),
    .illegal_o (res_d.illegal)
  );

  insn_field_steer u_steer (
    .cls_i     (res_d.cls),
    .f19_i     (insn_i[19:16]),
    .f15_i     (insn_i[15:12]),
    .f11_i     (insn_i[11:8]),
    .f3_i      (insn_i[3:0]),
    .reg_off_i (insn_i[25]),
    .rn_o      (res_d.rn),
    .rd_o      (res_d.rd),
    .rs_o      (res_d.rs),
    .rm_o      (res_d.rm)
  );

  assign res_d.cond = insn_i[31:28];

  insn_out_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .res_i   (res_d),
    .valid_o (valid_o),
    .res_o   (res_q)
  );

  assign class_o   = res_q.cls;
  assign cond_o    = res_q.cond;
  assign rn_o      = res_q.rn;
  assign rd_o      = res_q.rd;
  assign rs_o      = res_q.rs;
  assign rm_o      = res_q.rm;
  assign illegal_o = res_q.illegal;
endmodule

// File: rtl/insn_class_decoder_chk.sv
`timescale 1ns/1ps
module insn_class_decoder_chk
  import insn_cls_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               valid_o,
  input logic [NUM_CLS-1:0] class_o,
  input logic [REG_W-1:0]   rn_o,
  input logic [REG_W-1:0]   rd_o,
  input logic [REG_W-1:0]   rs_o,
  input logic [REG_W-1:0]   rm_o,
  input logic               illegal_o
);
  assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(class_o) == 1);

  assert_illegal_sdt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> class_o[CLS_SDT]);

  assert_bx_fields_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_BX] |-> (rn_o == '0 && rd_o == '0 && rs_o == '0));

  assert_branch_nofield_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o[CLS_BRANCH] |-> (rn_o == '0 && rd_o == '0 && rs_o == '0 && rm_o == '0));

  if (REG_OUT) begin : g_seq
    logic seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
    end

    assert_valid_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> (valid_o == $past(valid_i)));

    assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !$past(valid_i)) |-> ($stable(class_o) && $stable(rn_o) && $stable(rd_o)
                                       && $stable(rs_o) && $stable(rm_o) && $stable(illegal_o)));
  end else begin : g_comb
    always_comb begin
      if (rst_ni) assert_valid_pass_R11: assert (valid_o == valid_i);
    end
  end
endmodule

bind insn_class_decoder insn_class_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .class_o   (class_o),
  .rn_o      (rn_o),
  .rd_o      (rd_o),
  .rs_o      (rs_o),
  .rm_o      (rm_o),
  .illegal_o (illegal_o)
);

// File: tb/insn_class_decoder_tb.sv
`timescale 1ns/1ps
module insn_class_decoder_tb;
  // class bit positions as stated in the requirements
  localparam int K_DP = 0, K_SDT = 1, K_BLOCK = 2, K_BRANCH = 3, K_BX = 4, K_MUL = 5,
                 K_MULL = 6, K_SWAP = 7, K_HWR = 8, K_HWI = 9, K_UNDEF = 10, K_SWI = 11,
                 K_CPOP = 12, K_CPMEM = 13, K_CPREG = 14;

  typedef struct {
    bit         v;
    int         c;
    logic [3:0] cond, rn, rd, rs, rm;
    bit         ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] insn = '0;
  logic        valid_out, illegal;
  logic [14:0] cls;
  logic [3:0]  cond, rn, rd, rs, rm;

  int n_chk = 0, n_fail = 0;
  exp_t exp_q[$];
  exp_t last;

  always #4 clk = ~clk;

  insn_class_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .insn_i(insn),
    .valid_o(valid_out), .class_o(cls), .cond_o(cond), .rn_o(rn), .rd_o(rd),
    .rs_o(rs), .rm_o(rm), .illegal_o(illegal)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(int c);
    case (c)
      K_BX: return "R2";
      K_MUL, K_MULL: return "R3";
      K_SWAP: return "R4";
      K_HWR, K_HWI: return "R5";
      K_SDT, K_UNDEF: return "R6";
      K_DP: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] w);
    exp_t e;
    int top;
    e = '{v: 1'b1, c: 0, cond: w[31:28], rn: 4'd0, rd: 4'd0, rs: 4'd0, rm: 4'd0, ill: 1'b0};
    top = int'(w[27:24]);
    if ((w & 32'h0FFFFFF0) == 32'h012FFF10) begin
      e.c = K_BX; e.rm = w[3:0];
    end else if (top <= 3) begin
      if (top == 0 && w[7:4] == 4'h9) begin
        e.c = (w[23:22] == 2'b00) ? K_MUL : K_MULL;
        e.rd = w[19:16]; e.rn = w[15:12]; e.rs = w[11:8]; e.rm = w[3:0];
      end else if (w[27:23] == 5'b00010 && (w & 32'h00300FF0) == 32'h00000090) begin
        e.c = K_SWAP; e.rn = w[19:16]; e.rd = w[15:12]; e.rm = w[3:0];
      end else if (top <= 1 && w[7] && w[4] && int'(w[7:4]) > 9 && !(w[24] == 1'b0 && w[21] == 1'b1)) begin
        e.rn = w[19:16]; e.rd = w[15:12];
        if (w[22]) e.c = K_HWI;
        else begin e.c = K_HWR; e.rm = w[3:0]; end
      end else begin
        e.c = K_DP; e.rn = w[19:16]; e.rd = w[15:12]; e.rs = w[11:8]; e.rm = w[3:0];
      end
    end else if (top <= 7) begin
      if (w[25] && w[4]) e.c = K_UNDEF;
      else begin
        e.c = K_SDT; e.rn = w[19:16]; e.rd = w[15:12];
        if (w[25]) e.rm = w[3:0];
        e.ill = (w[24] == 1'b0) && (w[21] == 1'b1);
      end
    end else if (top <= 9) begin e.c = K_BLOCK; e.rn = w[19:16]; end
    else if (top <= 11) e.c = K_BRANCH;
    else if (top <= 13) begin e.c = K_CPMEM; e.rn = w[19:16]; end
    else if (top == 14) begin
      if (w[4]) begin e.c = K_CPREG; e.rd = w[15:12]; end
      else e.c = K_CPOP;
    end else e.c = K_SWI;
    return e;
  endfunction

  task automatic step(bit v, logic [31:0] w);
    exp_t e, g;
    string rq, fq;
    valid_in = v;
    insn = w;
    if (v) e = model(w);
    else begin e = last; e.v = 1'b0; end
    exp_q.push_back(e);
    @(negedge clk);
    g = exp_q.pop_front();
    last = g;
    rq = g.v ? req_of(g.c) : "R11";
    fq = !g.v ? "R11" : (g.c == K_DP) ? "R9" : (g.c == K_MUL || g.c == K_MULL) ? "R3" : "R10";
    chk(valid_out == g.v, "R11", "valid_o", valid_out, g.v);
    chk($countones(cls) == 1, "R1", "class_o onehot", cls, 15'(1) << g.c);
    chk(cls == (15'(1) << g.c), rq, "class_o", cls, 15'(1) << g.c);
    chk({rn, rd, rs, rm} == {g.rn, g.rd, g.rs, g.rm}, fq, "rn/rd/rs/rm",
        {rn, rd, rs, rm}, {g.rn, g.rd, g.rs, g.rm});
    chk(cond == g.cond, g.v ? "R10" : "R11", "cond_o", cond, g.cond);
    chk(illegal == g.ill, g.v ? "R8" : "R11", "illegal_o", illegal, g.ill);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] dir [$];
    dir = '{32'hE12FFF1E, 32'hE12FFF0E, 32'h012FFF13, 32'hE0321495, 32'hE0C32495,
            32'h10A12493, 32'hE1023091, 32'hE1423091, 32'hE19210B3, 32'hE1D213F4,
            32'hE0A210B3, 32'hE5921004, 32'hE7921003, 32'hE7000010, 32'hE4B21004,
            32'hE4921004, 32'hE5B21004, 32'hE8BD000F, 32'hEA000010, 32'hBB00FFFF,
            32'hED900100, 32'hEE012340, 32'hEE073F5E, 32'hEF000000, 32'hE0812003,
            32'h71A0F11F, 32'hE01210F3};
    repeat (3) @(negedge clk);
    // R12 reset values
    chk(valid_out == 1'b0, "R12", "valid_o in reset", valid_out, 0);
    chk(cls == 15'h0001, "R12", "class_o in reset", cls, 1);
    chk({cond, rn, rd, rs, rm, illegal} == '0, "R12", "fields in reset",
        {cond, rn, rd, rs, rm, illegal}, 0);
    last = '{v: 1'b0, c: K_DP, cond: 4'd0, rn: 4'd0, rd: 4'd0, rs: 4'd0, rm: 4'd0, ill: 1'b0};
    rst_n = 1'b1;
    step(1'b0, 32'hFFFFFFFF);
    foreach (dir[i]) begin
      step(1'b1, dir[i]);
      if (i % 3 == 0) step(1'b0, ~dir[i]);
    end
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (k % 5 == 0) r[7:4] = 4'hB;
      if (k % 7 == 0) r[27:25] = 3'b000;
      step(($urandom % 4) != 0, r);
    end
    step(1'b0, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule